// File: doc/BRIEF.md
# Bit-Reversed Write Address Generator

This block computes the effective address and the pointer update for a write access. When bit-reversed stepping is armed and the access qualifies, it walks a power-of-two data buffer in bit-reversed index order. Radix-2 FFT code uses this to scatter its results into natural order as it stores them. For every request it takes:

- the index of the selected pointer register and the pointer value,
- the addressing mode and a byte/word size flag,
- an arming bit and a pivot modifier.

One cycle later it returns:

- the effective address,
- the value to write back into the pointer, with a write-back enable,
- a flag that tells the write-path modulo unit to stand down.

Only the modifier is treated in reversed bit order. The pointer goes in and comes out in normal order. The pivot is half the buffer length in words and is scaled to bytes inside the block. The update is a reverse-carry addition: the carry moves from higher to lower address bits and falls off below bit 0. Bits above the buffer field therefore keep their value. A buffer of 2^N bytes must start on an address whose low N bits are zero. Requests that do not qualify get ordinary linear addressing with a step of 1 for bytes or 2 for words.

Top module: `brev_agu`

## Requirements
- R1: Reversal is active for a request only when all of these hold: the register index is not 15 (the stack pointer), `brev_en` is 1, and the mode is pre-increment (3'd3) or post-increment (3'd1).
- R2: Byte-sized accesses (`is_byte`=1) never use reversal. Such requests, and requests in the other modes, get linear addressing. Mode 3'd0 is plain indirect: the address is the pointer and there is no write-back. Mode 3'd2 is post-decrement and 3'd4 is pre-decrement. Codes 3'd5 to 3'd7 behave as plain indirect. The step is 1 for bytes and 2 for words. Pre-modes address the updated value and post-modes address the original pointer.
- R3: When reversal is active, the write-back value is the pointer plus `{pivot,1'b0}`, with the carry running from each bit to the next lower bit. The mode's normal increment is ignored and `wb_en` is 1.
- R4: When reversal is active, bit 0 of both `eff_addr` and `wb_value` is 0.
- R5: When reversal is active, pre-increment addresses the updated pointer and post-increment addresses the original pointer with bit 0 cleared.
- R6: `mod_inhibit` is 1 in the output cycle of exactly those requests for which reversal is active, and 0 otherwise.
- R7: With pivot 8, pre-increment and the write-back fed back as the next pointer, 16 steps from a base whose low 5 bits are zero visit each word index (address bits 4..1) once, in the order reverse4(1), reverse4(2), … Bits above bit 4 are unchanged, and the 16th step returns to the base.
- R8: Outputs are registered with one cycle of latency: `out_valid` equals the previous cycle's `req_valid`. Reset clears all outputs to 0, and the data outputs hold their values while no request arrives.
- R9: `wb_en` is 1 for the modify modes (3'd1 to 3'd4) and 0 for plain indirect and codes 3'd5 to 3'd7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A write address request is present |
| reg_idx | input | 4 | Index of the pointer register |
| ptr | input | 16 | Pointer value (byte address) |
| mode | input | 3 | Addressing mode code |
| is_byte | input | 1 | 1 for a byte access, 0 for a word access |
| brev_en | input | 1 | Arms bit-reversed stepping |
| pivot | input | 15 | Modifier: half the buffer length in words |
| out_valid | output | 1 | Result of the previous cycle's request |
| eff_addr | output | 16 | Effective address |
| wb_value | output | 16 | New pointer value |
| wb_en | output | 1 | Pointer write-back enable |
| mod_inhibit | output | 1 | Write-path modulo unit must stand down |

## Verification
Two things happen in the same cycle: the reversed update wraps, as the carry falls off below bit 0, and the forced clearing of bit 0 removes the trace of that carry. This is provoked by stepping a 16-word buffer up to its last index with pre- and post-increment. The check is that the effective address and the write-back return exactly to the buffer base. The same request also raises `mod_inhibit`, so any pairing of reversal with a modulo setup is judged by the inhibit flag matching the reversal conditions. Random requests with index 15, byte size and every mode code confirm that the linear path and the reversed path never mix.

// File: rtl/brev_agu_pkg.sv
package brev_agu_pkg;
  typedef enum logic [2:0] {
    AM_PLAIN   = 3'd0,
    AM_POSTINC = 3'd1,
    AM_POSTDEC = 3'd2,
    AM_PREINC  = 3'd3,
    AM_PREDEC  = 3'd4
  } am_e;

  typedef struct packed {
    logic active;   // reversal path selected
    logic pre;      // address the updated pointer
    logic modify;   // mode writes the pointer back
    logic incr;     // direction of the linear step
  } agu_dec_t;
endpackage

// File: rtl/brev_gate.sv
module brev_gate
  import brev_agu_pkg::*;
#(
  parameter int unsigned IDXW   = 4,
  parameter int unsigned SP_IDX = 15
) (
  input  logic [IDXW-1:0] reg_idx,
  input  logic [2:0]      mode,
  input  logic            is_byte,
  input  logic            brev_en,
  output agu_dec_t        dec
);
  logic inc_mode;
  logic not_sp;

  always_comb begin
    inc_mode   = (mode == AM_PREINC) || (mode == AM_POSTINC);
    not_sp     = (reg_idx != IDXW'(SP_IDX));
    dec.active = brev_en && not_sp && inc_mode && !is_byte;
    dec.pre    = (mode == AM_PREINC) || (mode == AM_PREDEC);
    dec.modify = (mode == AM_PREINC) || (mode == AM_POSTINC) ||
                 (mode == AM_PREDEC) || (mode == AM_POSTDEC);
    dec.incr   = inc_mode;
  end
endmodule

// File: rtl/brev_revadd.sv
module brev_revadd #(
  parameter int unsigned AW = 16
) (
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] m,
  output logic [AW-1:0] sum
);
  logic [AW-1:0] a_r, m_r, s_r;

  // mirror operands, add, mirror back: carry then runs toward bit 0
  for (genvar i = 0; i < AW; i++) begin : g_mirror
    assign a_r[i]        = a[AW-1-i];
    assign m_r[i]        = m[AW-1-i];
    assign sum[AW-1-i]   = s_r[i];
  end

  assign s_r = a_r + m_r;
endmodule

// File: rtl/brev_linear.sv
module brev_linear
  import brev_agu_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic [AW-1:0] ptr,
  input  agu_dec_t      dec,
  input  logic          is_byte,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] wb
);
  logic [AW-1:0] step;
  logic [AW-1:0] moved;

  always_comb begin
    step  = is_byte ? AW'(1) : AW'(2);
    moved = dec.incr ? (ptr + step) : (ptr - step);
    wb    = dec.modify ? moved : ptr;
    ea    = (dec.modify && dec.pre) ? moved : ptr;
  end
endmodule

// File: rtl/brev_agu.sv
module brev_agu
  import brev_agu_pkg::*;
#(
  parameter int unsigned IDXW   = 4,
  parameter int unsigned AW     = 16,
  parameter int unsigned SP_IDX = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [IDXW-1:0] reg_idx,
  input  logic [AW-1:0]   ptr,
  input  logic [2:0]      mode,
  input  logic            is_byte,
  input  logic            brev_en,
  input  logic [AW-2:0]   pivot,
  output logic            out_valid,
  output logic [AW-1:0]   eff_addr,
  output logic [AW-1:0]   wb_value,
  output logic            wb_en,
  output logic            mod_inhibit
);
  localparam logic [AW-1:0] WORD_MASK = ~AW'(1);

  agu_dec_t      dec;
  logic [AW-1:0] ptr_w;
  logic [AW-1:0] pivot_bytes;
  logic [AW-1:0] rev_sum;
  logic [AW-1:0] rev_next;
  logic [AW-1:0] lin_ea, lin_wb;
  logic [AW-1:0] ea_d, wb_d;
  logic          wb_en_d;
  logic          brev_hit;   // request accepted on the reversed path

  brev_gate #(.IDXW(IDXW), .SP_IDX(SP_IDX)) u_gate (
    .reg_idx (reg_idx),
    .mode    (mode),
    .is_byte (is_byte),
    .brev_en (brev_en),
    .dec     (dec)
  );

  assign ptr_w       = ptr & WORD_MASK;
  assign pivot_bytes = {pivot, 1'b0};

  brev_revadd #(.AW(AW)) u_revadd (
    .a   (ptr_w),
    .m   (pivot_bytes),
    .sum (rev_sum)
  );

  assign rev_next = rev_sum & WORD_MASK;

  brev_linear #(.AW(AW)) u_lin (
    .ptr     (ptr),
    .dec     (dec),
    .is_byte (is_byte),
    .ea      (lin_ea),
    .wb      (lin_wb)
  );

  assign brev_hit = req_valid && dec.active;

  always_comb begin
    if (dec.active) begin
      ea_d    = dec.pre ? rev_next : ptr_w;
      wb_d    = rev_next;
      wb_en_d = 1'b1;
    end else begin
      ea_d    = lin_ea;
      wb_d    = lin_wb;
      wb_en_d = dec.modify;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      eff_addr    <= '0;
      wb_value    <= '0;
      wb_en       <= 1'b0;
      mod_inhibit <= 1'b0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        eff_addr    <= ea_d;
        wb_value    <= wb_d;
        wb_en       <= wb_en_d;
        mod_inhibit <= dec.active;
      end else begin
        mod_inhibit <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/brev_agu_chk.sv
module brev_agu_chk #(
  parameter int unsigned IDXW   = 4,
  parameter int unsigned AW     = 16,
  parameter int unsigned SP_IDX = 15
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [IDXW-1:0] reg_idx,
  input logic [2:0]      mode,
  input logic            is_byte,
  input logic            brev_en,
  input logic            brev_hit,
  input logic            out_valid,
  input logic [AW-1:0]   eff_addr,
  input logic [AW-1:0]   wb_value,
  input logic            wb_en,
  input logic            mod_inhibit
);
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid && !mod_inhibit);
  a_r1_no_stack: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && reg_idx == IDXW'(SP_IDX)) |=> !mod_inhibit);
  a_r1_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !brev_en) |=> !mod_inhibit);
  a_r2_byte_linear: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_byte) |=> !mod_inhibit);
  a_r4_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mod_inhibit |-> (!eff_addr[0] && !wb_value[0]));
  a_r6_inhibit_tracks_hit: assert property (@(posedge clk) disable iff (!rst_n)
    brev_hit |=> mod_inhibit);
  a_r3_writes_back: assert property (@(posedge clk) disable iff (!rst_n)
    brev_hit |=> wb_en);
  a_r9_plain_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode == 3'd0) |=> !wb_en);
endmodule

bind brev_agu brev_agu_chk #(.IDXW(IDXW), .AW(AW), .SP_IDX(SP_IDX)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .reg_idx     (reg_idx),
  .mode        (mode),
  .is_byte     (is_byte),
  .brev_en     (brev_en),
  .brev_hit    (brev_hit),
  .out_valid   (out_valid),
  .eff_addr    (eff_addr),
  .wb_value    (wb_value),
  .wb_en       (wb_en),
  .mod_inhibit (mod_inhibit)
);

// File: tb/brev_agu_bench.sv
`timescale 1ns/1ps
module brev_agu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  reg_idx = '0;
  logic [15:0] ptr = '0;
  logic [2:0]  mode = '0;
  logic        is_byte = 1'b0;
  logic        brev_en = 1'b0;
  logic [14:0] pivot = '0;
  logic        out_valid;
  logic [15:0] eff_addr;
  logic [15:0] wb_value;
  logic        wb_en;
  logic        mod_inhibit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  brev_agu u_brev_agu (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .reg_idx(reg_idx),
    .ptr(ptr), .mode(mode), .is_byte(is_byte), .brev_en(brev_en),
    .pivot(pivot), .out_valid(out_valid), .eff_addr(eff_addr),
    .wb_value(wb_value), .wb_en(wb_en), .mod_inhibit(mod_inhibit)
  );

  // serial reverse-carry addition, scanning from the top bit downward
  function automatic logic [15:0] ref_revadd(logic [15:0] a, logic [15:0] b);
    logic c = 1'b0;
    logic [15:0] s;
    for (int i = 15; i >= 0; i--) begin
      s[i] = a[i] ^ b[i] ^ c;
      c    = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
    end
    return s;
  endfunction

  function automatic logic [3:0] rev4(logic [3:0] v);
    return {v[0], v[1], v[2], v[3]};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one request at a falling edge, compare at the next falling edge
  task automatic issue(logic [3:0] ri, logic [15:0] p, logic [2:0] md,
                       logic by, logic en, logic [14:0] pv);
    logic act;
    logic [15:0] step, nxt, e_ea, e_wb;
    logic e_wen;
    reg_idx = ri; ptr = p; mode = md; is_byte = by; brev_en = en; pivot = pv;
    req_valid = 1'b1;
    act  = en && (ri != 4'd15) && !by && (md == 3'd1 || md == 3'd3);
    step = by ? 16'd1 : 16'd2;
    if (act) begin
      nxt   = ref_revadd({p[15:1], 1'b0}, {pv, 1'b0});
      nxt[0] = 1'b0;
      e_wb  = nxt;
      e_ea  = (md == 3'd3) ? nxt : {p[15:1], 1'b0};
      e_wen = 1'b1;
    end else begin
      case (md)
        3'd1: begin e_ea = p;        e_wb = p + step; e_wen = 1'b1; end
        3'd2: begin e_ea = p;        e_wb = p - step; e_wen = 1'b1; end
        3'd3: begin e_ea = p + step; e_wb = p + step; e_wen = 1'b1; end
        3'd4: begin e_ea = p - step; e_wb = p - step; e_wen = 1'b1; end
        default: begin e_ea = p;     e_wb = p;        e_wen = 1'b0; end
      endcase
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 out_valid", {15'd0, out_valid}, 16'd1);
    chk(act ? "R5 eff_addr" : "R2 eff_addr", eff_addr, e_ea);
    chk(act ? "R3 wb_value" : "R2 wb_value", wb_value, e_wb);
    chk("R9 wb_en", {15'd0, wb_en}, {15'd0, e_wen});
    chk("R6 mod_inhibit", {15'd0, mod_inhibit}, {15'd0, act});
    if (act) chk("R4 lsb", {15'd0, eff_addr[0] | wb_value[0]}, 16'd0);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] p;
    logic [15:0] seen;
    logic [15:0] hold;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R8 reset out_valid", {15'd0, out_valid}, 16'd0);
    chk("R8 reset eff_addr", eff_addr, 16'd0);
    chk("R8 reset wb_value", wb_value, 16'd0);
    chk("R8 reset mod_inhibit", {15'd0, mod_inhibit}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 directed: stack pointer, disabled, decrement modes
    issue(4'd15, 16'h2010, 3'd3, 1'b0, 1'b1, 15'd8);
    issue(4'd3,  16'h2010, 3'd3, 1'b0, 1'b0, 15'd8);
    issue(4'd3,  16'h2010, 3'd4, 1'b0, 1'b1, 15'd8);
    // R2 byte access under arming
    issue(4'd3,  16'h2011, 3'd1, 1'b1, 1'b1, 15'd8);
    // R5 post-increment with odd pointer
    issue(4'd2,  16'h3013, 3'd1, 1'b0, 1'b1, 15'd8);

    // R8 hold while idle
    hold = wb_value;
    @(negedge clk);
    chk("R8 idle out_valid", {15'd0, out_valid}, 16'd0);
    chk("R8 idle hold", wb_value, hold);

    // R7 full 16-word walk with pre-increment
    p = 16'h4A00; seen = '0;
    for (int k = 1; k <= 16; k++) begin
      issue(4'd5, p, 3'd3, 1'b0, 1'b1, 15'd8);
      chk("R7 order", {12'd0, wb_value[4:1]}, {12'd0, rev4(4'(k))});
      chk("R7 upper bits", {wb_value[15:5], 5'd0}, 16'h4A00);
      seen[wb_value[4:1]] = 1'b1;
      p = wb_value;
    end
    chk("R7 all indices", seen, 16'hFFFF);
    chk("R7 wrap to base", p, 16'h4A00);

    // wrap with post-increment from last index
    issue(4'd5, 16'h4A1E, 3'd1, 1'b0, 1'b1, 15'd8);
    chk("R7 post wrap", wb_value, 16'h4A00);

    // random mix
    for (int n = 0; n < 400; n++) begin
      issue(4'($urandom), 16'($urandom), 3'($urandom), 1'($urandom),
            ($urandom % 4) != 0, 15'(1 << ($urandom % 6)));
      if (($urandom % 5) == 0) @(negedge clk);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule